// File: doc/BRIEF.md
# Multimode Timer Counter with Capture

This block is a single event-driven timer/counter. It advances on counted ticks. A counted tick needs a strobe from an internal power-of-two prescaler and the count event input in the same cycle. The counter runs up, down or up-down against a period register and compares its value with a compare register. It emits single-cycle overflow, underflow, terminal-count and compare/capture triggers, and it can raise a sticky interrupt flag from any of them.

Control comes from single-cycle start, reload, stop and capture event pulses. A 4-bit software command port offers the same four controls. The period and compare values are written into shadow copies. The counter only uses them once a terminal count or a reload moves them into the active registers, so a period can be changed on the fly without a short or torn cycle. A capture event samples the running count and keeps the previous sample in a second register. One-shot operation halts the counter at its first terminal count.

Top module: `mtc_timer`

## Requirements
- R1: While reset is held, the count, both capture registers, the running state, all four trigger outputs and the interrupt flag are zero.
- R2: Direction code 0 (and the unused code 3) counts up. On a counted tick that finds the count at or above the active period, `ovf_o` and `tc_o` pulse and the count goes to 0. Otherwise the count increments. Triggers and the new count appear together, one cycle after the tick's edge.
- R3: Direction code 1 counts down. A counted tick at count 0 pulses `unf_o` and `tc_o` and loads the period from the shadow register. Otherwise the count decrements.
- R4: Direction code 2 counts up-down. Going up, a tick at the period pulses `ovf_o` and turns the count downward. Going down, a tick at 0 pulses `unf_o` and `tc_o` and turns the count upward, so one full cycle spans twice the period in ticks.
- R5: A counted tick requires `ev_count` together with a prescaler strobe. The prescaler divides by 2^`cfg_psc` (1 to 128). It restarts on start or reload, so the first strobe comes 2^`cfg_psc` cycles after that event.
- R6: Writes go only to the shadow period/compare. Terminal count or reload copies shadow to active. A write in the same cycle as that copy stores the new value in the shadow, and the older shadow value becomes active.
- R7: Reload transfers the shadows, sets the count to the period (down mode) or 0 (other modes), sets the direction to upward in up-down mode and starts the counter.
- R8: Priority is stop, then reload, then start, then counting. A stopped counter ignores count events. Start resumes it without altering the count.
- R9: With `cfg_oneshot` set, the counter stops itself at its first terminal count. The count returns to its starting value: 0 in up and up-down modes, the period in down mode. It stays there until a start or reload.
- R10: `cc_o` pulses for a counted tick whose pre-tick count equals the active compare value.
- R11: A capture event stores the pre-edge count in `cap_o`, moves the old `cap_o` into `cap_buf_o` and pulses `cc_o`.
- R12: `sw_cmd` bit 0 starts, bit 1 reloads, bit 2 stops and bit 3 captures, exactly like the matching event inputs.
- R13: `irq_o` is set when a trigger pulses whose `irq_mask` bit is set (bit 0 overflow, 1 underflow, 2 terminal count, 3 compare/capture). It holds until `irq_clr`, and a new set beats a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir | input | 2 | Direction: 0 up, 1 down, 2 up-down |
| cfg_oneshot | input | 1 | Stop at the first terminal count |
| cfg_psc | input | 3 | Prescaler exponent, divide by 2^n |
| irq_mask | input | 4 | Interrupt enables per trigger |
| ev_start | input | 1 | Start event pulse |
| ev_reload | input | 1 | Reload event pulse |
| ev_stop | input | 1 | Stop event pulse |
| ev_count | input | 1 | Count qualifier |
| ev_capture | input | 1 | Capture event pulse |
| sw_cmd | input | 4 | Software start, reload, stop, capture |
| wr_period | input | 1 | Write strobe for the period shadow |
| wr_compare | input | 1 | Write strobe for the compare shadow |
| wr_data | input | W | Write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| count_o | output | W | Current count |
| running_o | output | 1 | Counter is running |
| cap_o | output | W | Latest captured count |
| cap_buf_o | output | W | Previous captured count |
| ovf_o | output | 1 | Overflow trigger |
| unf_o | output | 1 | Underflow trigger |
| tc_o | output | 1 | Terminal-count trigger |
| cc_o | output | 1 | Compare/capture trigger |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The case most likely to go wrong is a register write that lands in the very cycle a terminal count copies the shadow into the active register. The bench waits for the count to sit at the shrunken period and drives a new period write on the tick that wraps. It then measures the tick distance to each of the next two terminal counts: the first must follow the older shadow value and the second the newly written one. The same collision approach is used for stop against reload, and for an interrupt clear against a fresh terminal count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PSC_SEL_W = 3;
  localparam int SW_START  = 0;
  localparam int SW_RELOAD = 1;
  localparam int SW_STOP   = 2;
  localparam int SW_CAPT   = 3;
  localparam int NUM_REGS  = 2;   // period, compare

  typedef enum logic [1:0] {
    DIR_UP   = 2'b00,
    DIR_DOWN = 2'b01,
    DIR_UPDN = 2'b10
  } tmr_dir_e;

  // bit 0 overflow .. bit 3 compare/capture, matching the interrupt mask
  typedef struct packed {
    logic cc;
    logic tc;
    logic unf;
    logic ovf;
  } tmr_trig_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] pc_q, pc_d, mask;

  always_comb begin
    mask = ~({CNT_W{1'b1}} << sel);
    tick = ((pc_q & mask) == mask);
    pc_d = clr ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/tmr_dbuf.sv
module tmr_dbuf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         xfer,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o
);
  logic [W-1:0] shd_q, act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      if (wr)   shd_q <= wdata;
      if (xfer) act_q <= shd_q;   // older shadow wins a same-cycle write
    end
  end

  assign shadow_o = shd_q;
  assign active_o = act_q;
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cap_o,
  output logic [W-1:0] cap_buf_o
);
  logic [W-1:0] cap_q, buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      buf_q <= '0;
    end else if (cap) begin
      cap_q <= cnt;
      buf_q <= cap_q;
    end
  end

  assign cap_o     = cap_q;
  assign cap_buf_o = buf_q;
endmodule

// File: rtl/mtc_timer.sv
module mtc_timer
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_dir,
  input  logic                 cfg_oneshot,
  input  logic [PSC_SEL_W-1:0] cfg_psc,
  input  logic [3:0]           irq_mask,
  input  logic                 ev_start,
  input  logic                 ev_reload,
  input  logic                 ev_stop,
  input  logic                 ev_count,
  input  logic                 ev_capture,
  input  logic [3:0]           sw_cmd,
  input  logic                 wr_period,
  input  logic                 wr_compare,
  input  logic [W-1:0]         wr_data,
  input  logic                 irq_clr,
  output logic [W-1:0]         count_o,
  output logic                 running_o,
  output logic [W-1:0]         cap_o,
  output logic [W-1:0]         cap_buf_o,
  output logic                 ovf_o,
  output logic                 unf_o,
  output logic                 tc_o,
  output logic                 cc_o,
  output logic                 irq_o
);
  localparam int REG_PER = 0;
  localparam int REG_CMP = 1;

  logic rst_i_n;
  logic do_start, do_rel, do_stop, do_cap;
  logic tick, cnt_en, xfer;
  logic [NUM_REGS-1:0] wr_v;
  logic [W-1:0] shd [NUM_REGS];
  logic [W-1:0] act [NUM_REGS];
  logic [W-1:0] per_shd, per_act, cmp_act;
  logic [W-1:0] cnt_q, cnt_d;
  logic run_q, run_d, up_q, up_d, irq_q, irq_d;
  tmr_trig_t trig_q, trig_d;

  tmr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign do_start = ev_start   | sw_cmd[SW_START];
  assign do_rel   = ev_reload  | sw_cmd[SW_RELOAD];
  assign do_stop  = ev_stop    | sw_cmd[SW_STOP];
  assign do_cap   = ev_capture | sw_cmd[SW_CAPT];

  tmr_prescaler #(.SEL_W(PSC_SEL_W)) u_psc (
    .clk(clk), .rst_n(rst_i_n),
    .clr((do_start | do_rel) & ~do_stop),
    .sel(cfg_psc), .tick(tick)
  );

  assign wr_v[REG_PER] = wr_period;
  assign wr_v[REG_CMP] = wr_compare;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dbuf
    tmr_dbuf #(.W(W)) u_dbuf (
      .clk(clk), .rst_n(rst_i_n), .wr(wr_v[g]), .wdata(wr_data),
      .xfer(xfer), .shadow_o(shd[g]), .active_o(act[g])
    );
  end

  assign per_shd = shd[REG_PER];
  assign per_act = act[REG_PER];
  assign cmp_act = act[REG_CMP];

  tmr_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_i_n), .cap(do_cap), .cnt(cnt_q),
    .cap_o(cap_o), .cap_buf_o(cap_buf_o)
  );

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    up_d   = up_q;
    trig_d = '0;
    xfer   = 1'b0;
    cnt_en = run_q & tick & ev_count;
    if (do_stop) begin
      run_d = 1'b0;
    end else if (do_rel) begin
      xfer  = 1'b1;
      run_d = 1'b1;
      up_d  = (cfg_dir != DIR_DOWN);
      cnt_d = (cfg_dir == DIR_DOWN) ? per_shd : '0;
    end else if (do_start) begin
      run_d = 1'b1;
    end else if (cnt_en) begin
      trig_d.cc = (cnt_q == cmp_act);
      case (cfg_dir)
        DIR_DOWN: begin
          if (cnt_q == '0) begin
            trig_d.unf = 1'b1;
            trig_d.tc  = 1'b1;
            cnt_d      = per_shd;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        DIR_UPDN: begin
          if (up_q) begin
            if (cnt_q >= per_act) begin
              trig_d.ovf = 1'b1;
              up_d       = 1'b0;
              cnt_d      = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else if (cnt_q == '0) begin
            trig_d.unf = 1'b1;
            trig_d.tc  = 1'b1;
            up_d       = 1'b1;
            cnt_d      = (cfg_oneshot || per_shd == '0) ? '0 : W'(1);
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: begin
          if (cnt_q >= per_act) begin
            trig_d.ovf = 1'b1;
            trig_d.tc  = 1'b1;
            cnt_d      = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
      if (trig_d.tc) begin
        xfer = 1'b1;
        if (cfg_oneshot) run_d = 1'b0;
      end
    end
    trig_d.cc = trig_d.cc | do_cap;
    irq_d     = (irq_q & ~irq_clr) | (|(trig_d & irq_mask));
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      up_q   <= 1'b1;
      trig_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      up_q   <= up_d;
      trig_q <= trig_d;
      irq_q  <= irq_d;
    end
  end

  assign count_o   = cnt_q;
  assign running_o = run_q;
  assign ovf_o     = trig_q.ovf;
  assign unf_o     = trig_q.unf;
  assign tc_o      = trig_q.tc;
  assign cc_o      = trig_q.cc;
  assign irq_o     = irq_q;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_oneshot,
  input logic [3:0]   irq_mask,
  input logic         ev_start,
  input logic         ev_reload,
  input logic         ev_stop,
  input logic         ev_capture,
  input logic [3:0]   sw_cmd,
  input logic [W-1:0] count_o,
  input logic         running_o,
  input logic [W-1:0] cap_o,
  input logic [W-1:0] cap_buf_o,
  input logic         ovf_o,
  input logic         unf_o,
  input logic         tc_o,
  input logic         cc_o,
  input logic         irq_o
);
  // R2
  ovf_unf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o));

  // R4
  tc_has_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> (ovf_o || unf_o));

  // R8
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !ev_reload && !sw_cmd[1]) |=> $stable(count_o));

  // R8
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_start || sw_cmd[0]) && !ev_stop && !sw_cmd[2]) |=> running_o);

  // R9
  halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_o) |-> ($past(ev_stop || sw_cmd[2]) || (tc_o && $past(cfg_oneshot))));

  // R11
  capture_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_capture || sw_cmd[3]) |=>
      (cap_o == $past(count_o) && cap_buf_o == $past(cap_o) && cc_o));

  // R13
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|({cc_o, tc_o, unf_o, ovf_o} & $past(irq_mask))) |-> irq_o);
endmodule

bind mtc_timer tmr_chk #(.W(W)) u_tmr_chk (.*);

// File: tb/tb_mtc_timer.sv
module tb_mtc_timer;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cfg_dir;
  logic cfg_oneshot;
  logic [2:0] cfg_psc;
  logic [3:0] irq_mask;
  logic ev_start, ev_reload, ev_stop, ev_count, ev_capture;
  logic [3:0] sw_cmd;
  logic wr_period, wr_compare;
  logic [W-1:0] wr_data;
  logic irq_clr;
  logic [W-1:0] count_o, cap_o, cap_buf_o;
  logic running_o, ovf_o, unf_o, tc_o, cc_o, irq_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mtc_timer #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_oneshot(cfg_oneshot),
    .cfg_psc(cfg_psc), .irq_mask(irq_mask), .ev_start(ev_start),
    .ev_reload(ev_reload), .ev_stop(ev_stop), .ev_count(ev_count),
    .ev_capture(ev_capture), .sw_cmd(sw_cmd), .wr_period(wr_period),
    .wr_compare(wr_compare), .wr_data(wr_data), .irq_clr(irq_clr),
    .count_o(count_o), .running_o(running_o), .cap_o(cap_o),
    .cap_buf_o(cap_buf_o), .ovf_o(ovf_o), .unf_o(unf_o), .tc_o(tc_o),
    .cc_o(cc_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_reg(input bit is_cmp, input int val);
    wr_period  = !is_cmp;
    wr_compare = is_cmp;
    wr_data    = W'(val);
    step();
    wr_period  = 1'b0;
    wr_compare = 1'b0;
  endtask

  task automatic run_to_tc(input int lim, output int n);
    int i;
    n = 0;
    i = 0;
    while (n == 0 && i < lim) begin
      step();
      i++;
      if (tc_o) n = i;
    end
  endtask

  function automatic int fcnt(input int d, input int p, input int t);
    int r;
    if (d == 0) return t % (p + 1);
    if (d == 1) return p - (t % (p + 1));
    r = t % (2 * p);
    return (r <= p) ? r : 2 * p - r;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int plist[4] = '{1, 2, 3, 5};
    string mtag[3] = '{"R2", "R3", "R4"};
    int n;
    int capv;
    rst_n = 1'b0;
    cfg_dir = 2'd0; cfg_oneshot = 1'b0; cfg_psc = 3'd0; irq_mask = 4'd0;
    ev_start = 1'b0; ev_reload = 1'b0; ev_stop = 1'b0; ev_count = 1'b0;
    ev_capture = 1'b0; sw_cmd = 4'd0; wr_period = 1'b0; wr_compare = 1'b0;
    wr_data = '0; irq_clr = 1'b0;
    repeat (3) step();
    // R1 reset state
    check("R1 count", count_o, 0);
    check("R1 running", running_o, 0);
    check("R1 triggers", {cc_o, tc_o, unf_o, ovf_o}, 0);
    check("R1 irq", irq_o, 0);
    check("R1 capture", {cap_o, cap_buf_o}, 0);
    rst_n = 1'b1;
    repeat (4) step();

    // Sweep: direction x prescale x period, compare fixed at 1
    for (int d = 0; d < 3; d++) begin
      for (int s = 0; s < 3; s++) begin
        for (int pi = 0; pi < 4; pi++) begin
          int p;
          int nst;
          p = plist[pi];
          ev_count = 1'b0;
          cfg_dir = 2'(d); cfg_psc = 3'(s); cfg_oneshot = 1'b0;
          wr_reg(1'b0, p);
          wr_reg(1'b1, 1);
          ev_reload = 1'b1; step(); ev_reload = 1'b0;
          check({"R7 reload count ", mtag[d]}, count_o, (d == 1) ? p : 0);
          ev_count = 1'b1;
          nst = (2 * p + 3) << s;
          for (int k = 1; k <= nst; k++) begin
            int tt;
            int t;
            int f;
            logic [3:0] ex;
            step();
            tt = k >> s;
            ex = 4'b0000;
            if ((k % (1 << s)) == 0) begin
              t = tt - 1;
              f = fcnt(d, p, t);
              ex[3] = (f == 1);
              if (d == 0) begin
                ex[0] = (f == p); ex[2] = (f == p);
              end else if (d == 1) begin
                ex[1] = (f == 0); ex[2] = (f == 0);
              end else begin
                ex[0] = ((t % (2 * p)) == p);
                ex[1] = ((t % (2 * p)) == 0) && (t > 0);
                ex[2] = ex[1];
              end
            end
            check({mtag[d], "/R5 count"}, count_o, fcnt(d, p, tt));
            check({mtag[d], "/R10 triggers"}, {cc_o, tc_o, unf_o, ovf_o}, ex);
          end
          ev_count = 1'b0;
        end
      end
    end

    // R6 shadow/active period, including write colliding with transfer
    cfg_dir = 2'd0; cfg_psc = 3'd0; cfg_oneshot = 1'b0;
    wr_reg(1'b0, 10);
    wr_reg(1'b1, 200);
    ev_reload = 1'b1; step(); ev_reload = 1'b0;
    wr_reg(1'b0, 3);
    ev_count = 1'b1;
    run_to_tc(40, n);
    check("R6 write waits in shadow", n, 11);
    repeat (3) step();
    check("R6 count before collision", count_o, 3);
    wr_period = 1'b1; wr_data = W'(6); step(); wr_period = 1'b0;
    check("R6 tc at collision", {tc_o, count_o}, {1'b1, 16'd0});
    run_to_tc(40, n);
    check("R6 older shadow active", n, 4);
    run_to_tc(40, n);
    check("R6 colliding write active next", n, 7);

    // R8 stop/start/priority
    repeat (2) step();
    check("R8 pre-stop count", count_o, 2);
    ev_stop = 1'b1; step(); ev_stop = 1'b0;
    check("R8 stop halts", {running_o, count_o}, {1'b0, 16'd2});
    repeat (5) step();
    check("R8 stopped ignores count", count_o, 2);
    ev_start = 1'b1; step(); ev_start = 1'b0;
    check("R8 start keeps count", {running_o, count_o}, {1'b1, 16'd2});
    step();
    check("R8 resumed", count_o, 3);
    ev_stop = 1'b1; ev_reload = 1'b1; step(); ev_stop = 1'b0; ev_reload = 1'b0;
    check("R8 stop beats reload", {running_o, count_o}, {1'b0, 16'd3});
    ev_reload = 1'b1; ev_start = 1'b1; step(); ev_reload = 1'b0; ev_start = 1'b0;
    check("R8 reload beats start", {running_o, count_o}, {1'b1, 16'd0});

    // R5 count gating and a larger prescale
    ev_count = 1'b0; repeat (4) step();
    check("R5 no count without ev_count", count_o, 0);
    ev_count = 1'b1; repeat (2) step();
    check("R5 count with ev_count", count_o, 2);
    cfg_psc = 3'd3;
    ev_reload = 1'b1; step(); ev_reload = 1'b0;
    repeat (7) step();
    check("R5 divide by 8 before strobe", count_o, 0);
    step();
    check("R5 divide by 8 strobe", count_o, 1);
    cfg_psc = 3'd0;

    // R9 one-shot in each direction
    for (int d = 0; d < 3; d++) begin
      int expn;
      int home;
      ev_count = 1'b0;
      cfg_dir = 2'(d); cfg_oneshot = 1'b1;
      wr_reg(1'b0, 3);
      ev_reload = 1'b1; step(); ev_reload = 1'b0;
      ev_count = 1'b1;
      expn = (d == 2) ? 7 : 4;
      home = (d == 1) ? 3 : 0;
      run_to_tc(20, n);
      check({"R9 ticks to tc ", mtag[d]}, n, expn);
      check({"R9 halted at home ", mtag[d]}, {running_o, count_o}, {1'b0, 16'(home)});
      repeat (5) step();
      check({"R9 stays halted ", mtag[d]}, {running_o, count_o, tc_o}, {1'b0, 16'(home), 1'b0});
      ev_start = 1'b1; step(); ev_start = 1'b0;
      run_to_tc(20, n);
      check({"R9 restart run ", mtag[d]}, n, expn);
    end
    cfg_oneshot = 1'b0;

    // R11 capture while counting (compare kept out of range)
    cfg_dir = 2'd0;
    wr_reg(1'b0, 100);
    wr_reg(1'b1, 200);
    ev_reload = 1'b1; step(); ev_reload = 1'b0;
    ev_count = 1'b1;
    repeat (5) step();
    ev_capture = 1'b1; step(); ev_capture = 1'b0;
    check("R11 first capture", {cap_o, cap_buf_o, cc_o}, {16'd5, 16'd0, 1'b1});
    check("R11 count continues", count_o, 6);
    repeat (2) step();
    ev_capture = 1'b1; step(); ev_capture = 1'b0;
    check("R11 second capture", {cap_o, cap_buf_o, cc_o}, {16'd8, 16'd5, 1'b1});
    capv = 8;

    // R12 software commands
    sw_cmd = 4'b0100; step(); sw_cmd = 4'd0;
    check("R12 sw stop", running_o, 0);
    sw_cmd = 4'b0001; step(); sw_cmd = 4'd0;
    check("R12 sw start", running_o, 1);
    sw_cmd = 4'b0010; step(); sw_cmd = 4'd0;
    check("R12 sw reload", count_o, 0);
    repeat (3) step();
    sw_cmd = 4'b1000; step(); sw_cmd = 4'd0;
    check("R12 sw capture", {cap_o, cap_buf_o, cc_o}, {16'd3, 16'(capv), 1'b1});

    // R13 interrupt flag
    ev_count = 1'b0;
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
    irq_mask = 4'b0100;
    wr_reg(1'b0, 2);
    ev_reload = 1'b1; step(); ev_reload = 1'b0;
    check("R13 irq clear", irq_o, 0);
    ev_count = 1'b1;
    run_to_tc(10, n);
    check("R13 irq with tc", {irq_o, n[3:0]}, {1'b1, 4'd3});
    step();
    check("R13 irq sticky", irq_o, 1);
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
    check("R13 irq cleared", irq_o, 0);
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
    check("R13 set beats clear", {tc_o, irq_o}, 2'b11);
    irq_mask = 4'b0000;
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
    run_to_tc(10, n);
    check("R13 masked tc", {tc_o, irq_o}, 2'b10);

    done = 1'b1;
    finish_run();
  end
endmodule